// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block connects a simple request/acknowledge bus to the pins of an 8-bit NAND flash device. The bus has two address spaces, selected by `bus_bank`. The register space holds a chip control word and a ready status bit. In the bank window, a write becomes a command-latch, address-latch or data cycle on the flash, and the choice depends only on two offset bits. A read in the bank window is always a data cycle. The flash strobes are timed by parameters. `bus_ack` stays low until the whole flash cycle, including hold time, has finished.

The control word has a pair of bits for each chip. Bit 2·n enables chip n and bit 2·n+1 asserts its select. A select line is driven high only when both bits of its pair are set. The busy/ready pin passes through a two-flop synchronizer. Its synchronized value appears in the status register. When the `WAIT_BUSY` option is set, a flash cycle does not start while the device reports busy.

The sequencer has six states:
- `S_IDLE` waits for a request.
- `S_WAIT` holds off a bank cycle while the device is busy.
- `S_SETUP`, `S_PULSE` and `S_HOLD` time the strobe.
- `S_ACK` answers the bus for one cycle.

The transitions are:
- `S_IDLE` goes to `S_ACK` for a register access, a conflicting offset or a cycle with no live chip.
- `S_IDLE` goes to `S_WAIT` when a bank access meets a busy device and waiting is enabled.
- `S_IDLE` goes to `S_SETUP` otherwise.
- `S_WAIT` goes to `S_SETUP` once the device is ready.
- `S_SETUP` goes to `S_PULSE`, then to `S_HOLD`, then to `S_ACK`, each after its parameter count.
- `S_ACK` always returns to `S_IDLE`.

Top module: `nbs_top`

## Requirements
- R1: A bank write with offset bit 16 set and bit 15 clear is an address cycle: `fl_ale` is high from setup through hold and `fl_cle` stays low.
- R2: A bank write with offset bit 15 set and bit 16 clear is a command cycle: `fl_cle` is high from setup through hold and `fl_ale` stays low.
- R3: A bank write with both bits clear is a data cycle with neither latch high. Every bank read is a data cycle whatever its offset: `fl_re_n` pulses, `fl_dq_i` is captured and returned on `bus_rdata`.
- R4: A bank write with offset bits 16 and 15 both set is not issued. It is acknowledged one cycle after acceptance with `bus_err` high, and no strobe moves. `fl_cle` and `fl_ale` are never high together.
- R5: A register write at offset 0x50 loads the control word, and a read at 0x50 returns it. `fl_cs[n]` is high exactly when bits 2·n and 2·n+1 are both 1.
- R6: Writing 0 to the control word drives every `fl_cs` bit low.
- R7: A read at register offset 0x54 returns the ready pin in bit 0, after two synchronizing flops. A read accepted on the second clock edge after the pin rises still returns 0.
- R8: With `WAIT_BUSY` set, a bank cycle accepted while the synchronized ready is 0 keeps all strobes idle and withholds `bus_ack`. `fl_we_n` falls T_SETUP+3 edges after the pin rises.
- R9: A started cycle spends T_SETUP cycles in setup, T_PULSE cycles with `fl_we_n` (write) or `fl_re_n` (read) low, and T_HOLD cycles in hold. `bus_ack` is high for one cycle right after the hold. On writes, `fl_dq_oe` is high from setup through hold and carries the write byte.
- R10: A bank access while no chip has both its enable and assert bits set is acknowledged one cycle after acceptance, with no strobe movement and no error.
- R11: After reset, `fl_we_n` and `fl_re_n` are high, `fl_cle`, `fl_ale`, `fl_dq_oe`, `fl_cs` and `bus_ack` are low, and strobes stay idle outside a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held with its fields until `bus_ack` |
| bus_bank | input | 1 | 1 selects the bank window, 0 the register space |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | AW (17) | Offset within the selected space |
| bus_wdata | input | BW (8) | Write data |
| bus_rdata | output | BW (8) | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Completion with error (conflicting latch offset) |
| fl_cs | output | NCHIP (4) | Per-chip select, active high |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write enable, active low |
| fl_re_n | output | 1 | Read enable, active low |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rdy | input | 1 | Device ready pin, 1 = ready |

## Verification
The bench checks strobe phases every clock. A design that miscounts setup, pulse or hold moves `fl_we_n` or `bus_ack` one cycle early or late. The conflicting offset must complete with an error and no strobe. A design that prioritised one latch bit would instead issue an address cycle. A control word with only the assert bit set must skip the flash cycle. A design that selects chips on the assert bit alone would pulse `fl_we_n` there. The ready pin is read on exactly the second edge after it rises, and the busy hold-off is timed to the edge. Either check catches a synchronizer that lost a flop or a wait that ignores readiness.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_CMD  = 2'd1,
        K_ADDR = 2'd2
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WAIT  = 3'd1,
        S_SETUP = 3'd2,
        S_PULSE = 3'd3,
        S_HOLD  = 3'd4,
        S_ACK   = 3'd5
    } seq_state_e;
endpackage

// File: rtl/nbs_sync.sv
module nbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/nbs_decode.sv
module nbs_decode import nbs_pkg::*; (
    input  logic      we,
    input  logic      ale_bit,
    input  logic      cle_bit,
    output cyc_kind_e kind,
    output logic      conflict
);
    always_comb begin
        conflict = we && ale_bit && cle_bit;
        if (!we)          kind = K_DATA;
        else if (ale_bit) kind = K_ADDR;
        else if (cle_bit) kind = K_CMD;
        else              kind = K_DATA;
    end
endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm import nbs_pkg::*; #(
    parameter int T_SETUP   = 2,
    parameter int T_PULSE   = 3,
    parameter int T_HOLD    = 1,
    parameter bit WAIT_BUSY = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      bank,
    input  logic      we,
    input  cyc_kind_e kind,
    input  logic      conflict,
    input  logic      chip_live,
    input  logic      rdy_s,
    output logic      take,
    output logic      ack,
    output logic      err,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic      dq_oe,
    output logic      capture
);
    localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CNW  = $clog2(TMAX + 1);

    seq_state_e st, st_nx;
    logic [CNW-1:0] cnt;
    logic           cnt_last;
    cyc_kind_e      kind_q;
    logic           wr_q;
    logic           err_q;
    logic           phase;

    always_comb begin
        unique case (st)
            S_SETUP: cnt_last = (cnt == CNW'(T_SETUP - 1));
            S_PULSE: cnt_last = (cnt == CNW'(T_PULSE - 1));
            S_HOLD:  cnt_last = (cnt == CNW'(T_HOLD - 1));
            default: cnt_last = 1'b0;
        endcase
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (req) begin
                if (!bank || conflict || !chip_live) st_nx = S_ACK;
                else if (WAIT_BUSY && !rdy_s)        st_nx = S_WAIT;
                else                                 st_nx = S_SETUP;
            end
            S_WAIT:  if (rdy_s)    st_nx = S_SETUP;
            S_SETUP: if (cnt_last) st_nx = S_PULSE;
            S_PULSE: if (cnt_last) st_nx = S_HOLD;
            S_HOLD:  if (cnt_last) st_nx = S_ACK;
            S_ACK:   st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            kind_q <= K_DATA;
            wr_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
            if (take) begin
                kind_q <= kind;
                wr_q   <= we;
                err_q  <= bank && conflict;
            end
        end
    end

    always_comb begin
        take    = (st == S_IDLE) && req;
        phase   = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
        cle     = phase && (kind_q == K_CMD);
        ale     = phase && (kind_q == K_ADDR);
        dq_oe   = phase && wr_q;
        we_n    = !((st == S_PULSE) && wr_q);
        re_n    = !((st == S_PULSE) && !wr_q);
        ack     = (st == S_ACK);
        err     = ack && err_q;
        capture = (st == S_PULSE) && !wr_q && cnt_last;
    end

    p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
    p_we_re_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
    p_wait_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SETUP && $past(st) != S_SETUP) |-> ($past(rdy_s) || !WAIT_BUSY));
endmodule

// File: rtl/nbs_top.sv
module nbs_top import nbs_pkg::*; #(
    parameter int            NCHIP     = 4,
    parameter int            AW        = 17,
    parameter int            BW        = 8,
    parameter int            ALE_BIT   = 16,
    parameter int            CLE_BIT   = 15,
    parameter logic [AW-1:0] REG_CTRL  = 17'h00050,
    parameter logic [AW-1:0] REG_STAT  = 17'h00054,
    parameter int            T_SETUP   = 2,
    parameter int            T_PULSE   = 3,
    parameter int            T_HOLD    = 1,
    parameter bit            WAIT_BUSY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_bank,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BW-1:0]    bus_wdata,
    output logic [BW-1:0]    bus_rdata,
    output logic             bus_ack,
    output logic             bus_err,
    output logic [NCHIP-1:0] fl_cs,
    output logic             fl_cle,
    output logic             fl_ale,
    output logic             fl_we_n,
    output logic             fl_re_n,
    output logic [7:0]       fl_dq_o,
    output logic             fl_dq_oe,
    input  logic [7:0]       fl_dq_i,
    input  logic             fl_rdy
);
    localparam int CTW = 2 * NCHIP;

    logic [CTW-1:0] ctrl_q;
    logic [7:0]     dq_q;
    logic           rdy_s;
    logic           take;
    logic           capture;
    logic           conflict;
    cyc_kind_e      kind;

    for (genvar n = 0; n < NCHIP; n++) begin : g_cs
        assign fl_cs[n] = ctrl_q[2*n] && ctrl_q[2*n+1];
    end

    nbs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(fl_rdy), .q(rdy_s)
    );

    nbs_decode u_dec (
        .we(bus_we), .ale_bit(bus_addr[ALE_BIT]), .cle_bit(bus_addr[CLE_BIT]),
        .kind(kind), .conflict(conflict)
    );

    nbs_fsm #(
        .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .WAIT_BUSY(WAIT_BUSY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .bank(bus_bank), .we(bus_we),
        .kind(kind), .conflict(conflict), .chip_live(|fl_cs), .rdy_s(rdy_s),
        .take(take), .ack(bus_ack), .err(bus_err), .cle(fl_cle), .ale(fl_ale),
        .we_n(fl_we_n), .re_n(fl_re_n), .dq_oe(fl_dq_oe), .capture(capture)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            dq_q      <= '0;
            bus_rdata <= '0;
        end else begin
            if (take) dq_q <= bus_wdata[7:0];
            if (take && !bus_bank) begin
                if (bus_we) begin
                    if (bus_addr == REG_CTRL) ctrl_q <= bus_wdata[CTW-1:0];
                end else if (bus_addr == REG_CTRL) begin
                    bus_rdata <= BW'(ctrl_q);
                end else if (bus_addr == REG_STAT) begin
                    bus_rdata <= BW'(rdy_s);
                end else begin
                    bus_rdata <= '0;
                end
            end
            if (capture) bus_rdata <= BW'(fl_dq_i);
        end
    end

    assign fl_dq_o = dq_q;

    p_strobe_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_re_n) |-> (|fl_cs));
    p_err_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);
    p_cs_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n) |-> $stable(fl_cs));
endmodule

// File: tb/nbs_top_tb.sv
module nbs_top_tb;
    localparam int S = 2, P = 3, H = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_bank = 1'b0, bus_we = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_ack, bus_err;
    logic [3:0]  fl_cs;
    logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
    logic [7:0]  fl_dq_o;
    logic [7:0]  fl_dq_i = 8'h00;
    logic        fl_rdy = 1'b1;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    nbs_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_bank(bus_bank), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .fl_cs(fl_cs), .fl_cle(fl_cle),
        .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o),
        .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_rdy(fl_rdy)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Pins vector {ack, err, cle, ale, we_n, re_n, oe}
    function automatic logic [6:0] pins();
        return {bus_ack, bus_err, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe};
    endfunction

    // Reference: one access, compared every clock. live=0 means immediate ack.
    task automatic access(input bit bank, input bit we, input logic [16:0] a,
                          input logic [7:0] wd, input bit k_cmd, input bit k_adr,
                          input bit live, input bit e_err, input string rq,
                          output logic [7:0] rd);
        int n;
        logic [6:0] exp;
        @(negedge clk);
        bus_req = 1'b1; bus_bank = bank; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        n = live ? (S + P + H) : 0;
        for (int c = 0; c <= n; c++) begin
            @(negedge clk);
            if (c == n) exp = {1'b1, e_err, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            else begin
                bit pul;
                pul = (c >= S) && (c < S + P);
                exp = {1'b0, 1'b0, k_cmd, k_adr, !(pul && we), !(pul && !we), we};
            end
            chk(pins() == exp, {rq, " R9 phase"}, 32'(pins()), 32'(exp));
            if (c < n && we) chk(fl_dq_o == wd, {rq, " R9 dq"}, 32'(fl_dq_o), 32'(wd));
        end
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic reg_wr(input logic [16:0] a, input logic [7:0] d);
        logic [7:0] unused_rd;
        access(1'b0, 1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, "reg write", unused_rd);
    endtask

    task automatic reg_rd(input logic [16:0] a, output logic [7:0] d);
        access(1'b0, 1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "reg read", d);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= 200000) begin
                total++; bad++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rd;
        int waitc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(pins() == 7'b0000110, "R11 reset pins", 32'(pins()), 32'h06);
        chk(fl_cs == 4'h0, "R11 reset cs", 32'(fl_cs), 0);

        // R5 control word: chip 0 enable+assert
        reg_wr(17'h00050, 8'h03);
        chk(fl_cs == 4'b0001, "R5 cs chip0", 32'(fl_cs), 1);
        reg_rd(17'h00050, rd);
        chk(rd == 8'h03, "R5 readback", 32'(rd), 3);

        // R2 command, R1 address, R3 data write
        access(1'b1, 1'b1, 17'h08000, 8'h90, 1'b1, 1'b0, 1'b1, 1'b0, "R2 cmd", rd);
        access(1'b1, 1'b1, 17'h10000, 8'h12, 1'b0, 1'b1, 1'b1, 1'b0, "R1 addr", rd);
        access(1'b1, 1'b1, 17'h00000, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, "R3 data wr", rd);

        // R3 read at a latch offset is still a data cycle
        fl_dq_i = 8'h5C;
        access(1'b1, 1'b0, 17'h10000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R3 read", rd);
        chk(rd == 8'h5C, "R3 read data", 32'(rd), 32'h5C);
        fl_dq_i = 8'hE1;
        access(1'b1, 1'b0, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R3 read2", rd);
        chk(rd == 8'hE1, "R3 read data2", 32'(rd), 32'hE1);

        // R4 conflicting offset: error, no strobes
        access(1'b1, 1'b1, 17'h18000, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, "R4 conflict", rd);

        // R5 chip 3 only
        reg_wr(17'h00050, 8'hC0);
        chk(fl_cs == 4'b1000, "R5 cs chip3", 32'(fl_cs), 8);
        access(1'b1, 1'b1, 17'h00000, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, "R5 chip3 wr", rd);

        // R10 assert without enable: skipped
        reg_wr(17'h00050, 8'h20);
        chk(fl_cs == 4'b0000, "R10 cs none", 32'(fl_cs), 0);
        access(1'b1, 1'b1, 17'h08000, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, "R10 skip", rd);

        // R6 write zero clears all
        reg_wr(17'h00050, 8'hFF);
        chk(fl_cs == 4'hF, "R6 all on", 32'(fl_cs), 32'hF);
        reg_wr(17'h00050, 8'h00);
        chk(fl_cs == 4'h0, "R6 all off", 32'(fl_cs), 0);
        reg_rd(17'h00050, rd);
        chk(rd == 8'h00, "R6 readback", 32'(rd), 0);

        // R7 status through two flops
        @(negedge clk); fl_rdy = 1'b0;
        repeat (4) @(negedge clk);
        reg_rd(17'h00054, rd);
        chk(rd == 8'h00, "R7 busy", 32'(rd), 0);
        repeat (2) @(negedge clk);
        fl_rdy = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b1; bus_bank = 1'b0; bus_we = 1'b0; bus_addr = 17'h00054;
        @(posedge clk);
        @(negedge clk);
        chk(bus_ack == 1'b1, "R7 ack", 32'(bus_ack), 1);
        chk(bus_rdata == 8'h00, "R7 two-flop latency", 32'(bus_rdata), 0);
        bus_req = 1'b0;
        reg_rd(17'h00054, rd);
        chk(rd == 8'h01, "R7 ready", 32'(rd), 1);

        // R8 wait on busy
        reg_wr(17'h00050, 8'h03);
        fl_rdy = 1'b0;
        repeat (4) @(negedge clk);
        bus_req = 1'b1; bus_bank = 1'b1; bus_we = 1'b1; bus_addr = 17'h0; bus_wdata = 8'h44;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(pins() == 7'b0000110, "R8 held idle", 32'(pins()), 32'h06);
        end
        fl_rdy = 1'b1;
        waitc = 0;
        while (fl_we_n && waitc < 20) begin
            @(negedge clk);
            waitc++;
        end
        chk(waitc == S + 3, "R8 start delay", 32'(waitc), 32'(S + 3));
        waitc = 0;
        while (!bus_ack && waitc < 20) begin
            @(negedge clk);
            waitc++;
        end
        chk(waitc == P + H, "R8 R9 finish", 32'(waitc), 32'(P + H));
        bus_req = 1'b0;
        @(negedge clk);
        chk(pins() == 7'b0000110, "R11 idle after", 32'(pins()), 32'h06);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule